// File: doc/BRIEF.md
# Snoop control register file

This block is the small register window that software uses to set up and watch a multiprocessor snoop control unit. It decodes exact 8-bit offsets inside a 256-byte window. Three things live there. The first is a single enable bit. The second is a read-only word that reports how many CPUs the unit serves. The third is a 32-bit power-status word holding one byte per CPU, which can be written and read in pieces. Every other offset in the window is a hole: it reads as zero, and writes to it are dropped. This includes the filter-range, access-control and cache-invalidate offsets.

Requests arrive on one synchronous port, given as valid, write flag, offset, access size in bytes, and write data. The block applies no back-pressure. A request is taken on every clock edge at which `req_valid` is high, whether it is a read or a write. Back-to-back requests are allowed in every cycle. Exactly one cycle later, `rsp_valid` pulses high for one cycle together with `rsp_rdata`. The response cannot be stalled, so the requester must be ready to take it.

Top module: `snoop_ctl_regs`

## Requirements
- R1: A write at offset 0x00 with a legal size stores `req_wdata[0]` as the enable bit. A read at 0x00 returns that bit in bit 0 and zero in bits 31:1.
- R2: A read at offset 0x04 returns `(((1<<NCPU)-1)<<4) | (NCPU-1)`, which is 0x72 for three CPUs. Writes to 0x04 change nothing.
- R3: A write at offset 0x08+k (k = 0..3) of size S bytes works on the power-status word. The value `req_wdata & M` is shifted left by 8*k bits, where M is 0xFF, 0xFFFF or 0xFFFFFFFF for S = 1, 2 or 4. Only the bits of `M<<(8*k)` that fall inside the 32-bit word are replaced. Bits shifted past bit 31 are dropped.
- R4: A read at offset 0x08+k returns the power-status word shifted right by 8*k bits, with zeros filled in from the top.
- R5: Every offset other than 0x00, 0x04 and 0x08 to 0x0B reads as zero, and a write there changes no state. This includes 0x0C, 0x40, 0x44, 0x50 and 0x54.
- R6: A write whose `req_size` is not 1, 2 or 4 changes neither the enable bit nor the power-status word.
- R7: Reset (`rst_n` low) clears the enable bit and the power-status word to zero.
- R8: Every request taken while `req_valid` is high gives `rsp_valid` high on the next cycle. A cycle with no request gives `rsp_valid` low on the next cycle. `rsp_rdata` carries the read value for reads and zero for writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle; always accepted |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte offset inside the window |
| req_size | input | 3 | Access size in bytes (1, 2, 4 legal for writes) |
| req_wdata | input | 32 | Write data, least significant byte first |
| rsp_valid | output | 1 | One-cycle pulse, one cycle after each request |
| rsp_rdata | output | 32 | Read result (zero for writes) |

## Verification
A write and the response to the request before it can fall in the same cycle. In that same edge, the state the write changes must be visible to a read issued on the very next cycle. The bench provokes this by issuing every request back-to-back. It pairs each write with an immediate read of the same offset, followed by reads of the enable and power-status offsets. The sweep covers every offset with every size code 0 to 7. Each response is judged against a model in the bench that applies the mask-and-shift rule arithmetically.

// File: rtl/scu_regs_pkg.sv
package scu_regs_pkg;
  localparam int SZW = 3;

  localparam logic [7:0] OFF_CTL = 8'h00;
  localparam logic [7:0] OFF_CFG = 8'h04;
  localparam logic [7:0] OFF_PWR = 8'h08;

  typedef enum logic [SZW-1:0] {
    SZ_BYTE = 3'd1,
    SZ_HALF = 3'd2,
    SZ_WORD = 3'd4
  } acc_size_e;

  function automatic logic size_legal(input logic [SZW-1:0] sz);
    return (sz == SZ_BYTE) || (sz == SZ_HALF) || (sz == SZ_WORD);
  endfunction

  // CPU presence mask in bits [7:4], count minus one in the low bits
  function automatic logic [31:0] cpu_cfg_word(input int n);
    logic [31:0] m;
    m = (32'd1 << n) - 32'd1;
    return (m << 4) | 32'(n - 1);
  endfunction
endpackage

// File: rtl/scu_pwr_status.sv
module scu_pwr_status
  import scu_regs_pkg::*;
#(
  parameter int DW = 32,
  localparam int LANES = DW / 8,
  localparam int LW = $clog2(LANES),
  localparam int CW = ((LW > SZW) ? LW : SZW) + 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [LW-1:0]  lane,
  input  logic [SZW-1:0] size,
  input  logic [DW-1:0]  wdata,
  output logic [DW-1:0]  word
);
  logic [CW-1:0] lane_w;
  logic [CW-1:0] lane_end;

  assign lane_w   = CW'(lane);
  assign lane_end = lane_w + CW'(size);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic          hit;
    logic [CW-1:0] rel;
    logic [DW-1:0] shifted;
    logic [7:0]    byte_q;

    // byte i takes source byte (i - lane) when it lies in [lane, lane+size)
    always_comb begin
      hit     = wr_en && (CW'(i) >= lane_w) && (CW'(i) < lane_end);
      rel     = CW'(i) - lane_w;
      shifted = wdata >> {rel[LW-1:0], 3'b000};
    end

    always_ff @(posedge clk) begin
      if (!rst_n)   byte_q <= '0;
      else if (hit) byte_q <= shifted[7:0];
    end

    assign word[8*i +: 8] = byte_q;
  end

  // R3: a one-byte write to lane 0 leaves the upper bytes untouched
  a_r3_byte_write_keeps_upper: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && size == SZ_BYTE && lane == '0) |=> $stable(word[DW-1:8]));

  // R3: a full-word write to lane 0 replaces the whole word
  a_r3_word_write_replaces: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && size == SZ_WORD && lane == '0) |=> (word == $past(wdata)));
endmodule

// File: rtl/scu_rd_select.sv
module scu_rd_select
  import scu_regs_pkg::*;
#(
  parameter int DW = 32,
  parameter int NCPU = 4
) (
  input  logic [7:0]    addr,
  input  logic          ctl_bit,
  input  logic [DW-1:0] pwr_word,
  output logic [DW-1:0] rdata
);
  localparam logic [DW-1:0] CFG_VAL = DW'(cpu_cfg_word(NCPU));

  always_comb begin
    rdata = '0;
    if (addr == OFF_CTL)
      rdata = DW'(ctl_bit);
    else if (addr == OFF_CFG)
      rdata = CFG_VAL;
    else if (addr[7:2] == OFF_PWR[7:2])
      rdata = pwr_word >> {addr[1:0], 3'b000};
  end
endmodule

// File: rtl/snoop_ctl_regs.sv
module snoop_ctl_regs
  import scu_regs_pkg::*;
#(
  parameter int NCPU = 4,
  parameter int DW = 32,
  localparam int LANES = DW / 8,
  localparam int LW = $clog2(LANES)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  input  logic           req_write,
  input  logic [7:0]     req_addr,
  input  logic [SZW-1:0] req_size,
  input  logic [DW-1:0]  req_wdata,
  output logic           rsp_valid,
  output logic [DW-1:0]  rsp_rdata
);
  logic          wr_ok;
  logic          ctl_q;
  logic          pwr_sel;
  logic [DW-1:0] pwr_word;
  logic [DW-1:0] rd_data;

  assign wr_ok   = req_valid && req_write && size_legal(req_size);
  assign pwr_sel = (req_addr[7:2] == OFF_PWR[7:2]);

  always_ff @(posedge clk) begin
    if (!rst_n)
      ctl_q <= 1'b0;
    else if (wr_ok && req_addr == OFF_CTL)
      ctl_q <= req_wdata[0];
  end

  scu_pwr_status #(.DW(DW)) u_pwr (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_en (wr_ok && pwr_sel),
    .lane  (req_addr[LW-1:0]),
    .size  (req_size),
    .wdata (req_wdata),
    .word  (pwr_word)
  );

  scu_rd_select #(.DW(DW), .NCPU(NCPU)) u_rd (
    .addr     (req_addr),
    .ctl_bit  (ctl_q),
    .pwr_word (pwr_word),
    .rdata    (rd_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid;
      rsp_rdata <= (req_valid && !req_write) ? rd_data : '0;
    end
  end

  // R8: a response follows every request, and only requests
  a_r8_rsp_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  a_r8_no_rsp_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  // R1: enable read returns a single bit
  a_r1_ctl_read_one_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_addr == OFF_CTL) |=> (rsp_rdata[DW-1:1] == '0));

  // R6: illegal write sizes leave all state alone
  a_r6_bad_size_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && !size_legal(req_size)) |=> ($stable(ctl_q) && $stable(pwr_word)));

  // R5: writes to holes leave all state alone
  a_r5_hole_write_no_change: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && req_addr != OFF_CTL && req_addr[7:2] != OFF_PWR[7:2])
      |=> ($stable(ctl_q) && $stable(pwr_word)));

  // R5: reads of holes return zero
  a_r5_hole_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_addr != OFF_CTL && req_addr != OFF_CFG
      && req_addr[7:2] != OFF_PWR[7:2]) |=> (rsp_rdata == '0));
endmodule

// File: tb/sim_snoop_ctl_regs.sv
module sim_snoop_ctl_regs;
  localparam int NCPU = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [2:0]  req_size = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  logic        m_ctl;
  logic [31:0] m_pwr;
  logic [31:0] lfsr = 32'h1357_9BDF;

  always #10 clk = ~clk;

  snoop_ctl_regs #(.NCPU(NCPU)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] exp_read(input logic [7:0] a);
    if (a == 8'h00) return {31'b0, m_ctl};
    if (a == 8'h04) return (((32'd1 << NCPU) - 1) << 4) | (NCPU - 1);
    if (a >= 8'h08 && a <= 8'h0B) return m_pwr >> (8 * (a - 8'h08));
    return 32'h0;
  endfunction

  function automatic void model_write(input logic [7:0] a, input logic [2:0] sz,
                                      input logic [31:0] d);
    logic [31:0] mask;
    int sh;
    if (!(sz == 3'd1 || sz == 3'd2 || sz == 3'd4)) return;
    mask = (sz == 3'd4) ? 32'hFFFF_FFFF : ((32'd1 << (8 * sz)) - 32'd1);
    if (a == 8'h00) m_ctl = d[0];
    if (a >= 8'h08 && a <= 8'h0B) begin
      sh = 8 * (a - 8'h08);
      m_pwr = (m_pwr & ~(mask << sh)) | ((d & mask) << sh);
    end
  endfunction

  function automatic string tag_of(input logic [7:0] a, input logic [2:0] sz, input bit rd);
    if (a == 8'h00) return "R1";
    if (a == 8'h04) return "R2";
    if (a >= 8'h08 && a <= 8'h0B) begin
      if (rd && a != 8'h08) return "R4";
      return (sz == 3'd1 || sz == 3'd2 || sz == 3'd4) ? "R3" : "R6";
    end
    return "R5";
  endfunction

  // called at a falling edge; returns the response seen at the next falling edge
  task automatic op(input bit wr, input logic [7:0] a, input logic [2:0] sz,
                    input logic [31:0] d, output logic [31:0] rd);
    req_valid = 1'b1;
    req_write = wr;
    req_addr  = a;
    req_size  = sz;
    req_wdata = d;
    @(negedge clk);
    chk("R8 rsp_valid", {31'b0, rsp_valid}, 32'd1);
    rd = rsp_rdata;
  endtask

  task automatic rd_chk(input logic [7:0] a, input string tag);
    logic [31:0] r;
    op(1'b0, a, 3'd4, 32'h0, r);
    chk(tag, r, exp_read(a));
  endtask

  task automatic wr_do(input logic [7:0] a, input logic [2:0] sz, input logic [31:0] d);
    logic [31:0] r;
    op(1'b1, a, sz, d, r);
    model_write(a, sz, d);
    chk("R8 write rdata", r, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    m_ctl = 1'b0;
    m_pwr = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 idle", {31'b0, rsp_valid}, 32'd0);
    rd_chk(8'h00, "R7 enable after reset");
    rd_chk(8'h08, "R7 power after reset");

    // full read sweep of the window in its reset state
    for (int a = 0; a < 256; a++) rd_chk(8'(a), tag_of(8'(a), 3'd4, 1'b1));

    // directed corner cases of the shift rule
    wr_do(8'h08, 3'd4, 32'hDEAD_BEEF);
    rd_chk(8'h09, "R4 shift 8");
    rd_chk(8'h0B, "R4 shift 24");
    wr_do(8'h0B, 3'd2, 32'h1234_5678);
    rd_chk(8'h08, "R3 halfword at top lane");
    wr_do(8'h0A, 3'd4, 32'hA1B2_C3D4);
    rd_chk(8'h08, "R3 word at lane 2");
    wr_do(8'h0C, 3'd4, 32'hFFFF_FFFF);
    rd_chk(8'h08, "R5 invalidate write");
    rd_chk(8'h0C, "R5 invalidate read");
    wr_do(8'h00, 3'd3, 32'h1);
    rd_chk(8'h00, "R6 enable odd size");
    wr_do(8'h04, 3'd4, 32'h0);
    rd_chk(8'h04, "R2 config after write");

    // exhaustive offset x size sweep, all requests back-to-back
    for (int a = 0; a < 256; a++) begin
      for (int s = 0; s < 8; s++) begin
        lfsr = lfsr * 32'd1103515245 + 32'd12345;
        wr_do(8'(a), 3'(s), lfsr);
        rd_chk(8'(a), tag_of(8'(a), 3'(s), 1'b1));
        rd_chk(8'h00, tag_of(8'(a), 3'(s), 1'b0));
        rd_chk(8'h08, tag_of(8'(a), 3'(s), 1'b0));
      end
    end

    req_valid = 1'b0;
    @(negedge clk);
    chk("R8 idle after traffic", {31'b0, rsp_valid}, 32'd0);

    // reset clears state mid-run
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    m_ctl = 1'b0;
    m_pwr = 32'h0;
    @(negedge clk);
    rd_chk(8'h00, "R7 enable re-reset");
    rd_chk(8'h08, "R7 power re-reset");
    req_valid = 1'b0;
    @(negedge clk);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule